// File: doc/BRIEF.md
# Completion error reporting encoder

This block sits between application logic and the downstream error logging of a PCIe function. Application logic raises error events (completer abort, unexpected completion, unsupported request for posted or for non-posted traffic) together with the identity of the reporting function and an optional 128-bit TLP header. The block turns each event into a one-cycle strobe on a 7-bit error vector. The header-log bit and the header go with the strobe when logging was asked for.

A built-in monitor keeps one timer slot per outstanding non-posted request tag. A request that gets no completion within the timeout window (50 ms at the clock rate, or a short cycle count for simulation) produces a completion-timeout report. The report goes on the correctable or the uncorrectable timeout bit, as a configuration input selects. Events that arrive together are queued and sent one per cycle, lowest error bit first, so no event is lost.

Top module: `cplerr_reporter`

## Requirements
- R1: After reset `err_strb`, `err_pf`, `err_vf_act`, `err_vf` and `err_hdr` are all zero and `ev_ready` is 1.
- R2: An accepted event whose `ev_kind` bit j is set (bit 0 completer abort, bit 1 unexpected completion, bit 2 posted unsupported request, bit 3 non-posted unsupported request) produces `err_strb` bit j+2 high for exactly one cycle, in the cycle after acceptance when nothing else is queued. At most one of `err_strb[5:0]` is high in any cycle.
- R3: An event with several `ev_kind` bits set is sent as separate strobes on consecutive cycles, lowest bit first.
- R4: `err_strb[6]` (header log) is high together with an application error strobe exactly when that event had `ev_log` set, and `err_hdr` then carries `ev_hdr`. In every other cycle `err_hdr` is zero.
- R5: Each strobe carries the reporting function's PF number on `err_pf` and its VF flag on `err_vf_act`. When the VF flag is set, `err_vf` carries the 11-bit VF offset; otherwise `err_vf` is zero.
- R6: Accepted events are reported in acceptance order and none is dropped. `ev_ready` goes low while FIFO_DEPTH events are held, and an event presented while `ev_ready` is low is not accepted.
- R7: A request issued on tag t with no completion is reported once, TO cycles after issue: the issue is taken at edge I and the strobe is registered at edge I+TO+1. The strobe carries the identity given at issue.
- R8: A completion for the tag taken at or before edge I+TO cancels the timeout, and no report follows.
- R9: A timeout is reported on `err_strb[0]` when `cfg_to_uncorr` is 0 and on `err_strb[1]` when it is 1. The value is sampled in the cycle the report is emitted.
- R10: A pending timeout report is sent before any queued application event strobe. The interrupted event resumes in the next cycle.
- R11: Timeout strobes never carry the header-log bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_to_uncorr | input | 1 | 1: timeouts reported as uncorrectable (bit 1); 0: correctable (bit 0) |
| ev_kind | input | 4 | Error kinds of the presented event; nonzero means an event is offered |
| ev_log | input | 1 | Header logging requested for this event |
| ev_hdr | input | HDR_W (128) | Header of the offending TLP |
| ev_pf | input | PF_W (2) | PF number (parent PF for a VF) |
| ev_vf_act | input | 1 | Reporter is a virtual function |
| ev_vf | input | VF_W (11) | VF offset of the reporter |
| ev_ready | output | 1 | Event queue can take an event this cycle |
| rq_issue | input | 1 | Non-posted request issued on `rq_tag` |
| rq_tag | input | TAG_W (3) | Tag of the issued request |
| rq_pf | input | PF_W (2) | PF number of the requester |
| rq_vf_act | input | 1 | Requester is a virtual function |
| rq_vf | input | VF_W (11) | VF offset of the requester |
| rq_done | input | 1 | Completion received for `rq_done_tag` |
| rq_done_tag | input | TAG_W (3) | Tag whose completion arrived |
| err_strb | output | 7 | One-cycle error strobe vector (bit 6 = header log) |
| err_pf | output | PF_W (2) | PF number for the strobe |
| err_vf_act | output | 1 | VF flag for the strobe |
| err_vf | output | VF_W (11) | VF offset for the strobe |
| err_hdr | output | HDR_W (128) | Logged header for the strobe |

## Verification
Each single error kind is applied with and without header logging, and with both PF and VF identities. This separates the bit mapping, the coupling of the log bit to the header, and the zeroing of the VF offset. An event with three kinds shows the lowest-first serialisation. Five four-kind events pushed back to back fill the queue and show that order holds and nothing is lost under backpressure. Timeouts are tried in both configurations, with a completion landing on the last cancelling edge, and with an expiry that falls while an application event is mid-drain. Together these show the exact expiry cycle, cancellation, the bit selection, and priority over queued events.

// File: rtl/cplerr_pkg.sv
package cplerr_pkg;
   localparam int ERR_W    = 7;
   localparam int KIND_W   = 4;
   localparam int B_TO_COR = 0;
   localparam int B_TO_UNC = 1;
   localparam int B_APP0   = 2;
   localparam int B_LOG    = 6;

   // isolate the lowest set bit of a kind mask
   function automatic logic [KIND_W-1:0] lowest_kind(input logic [KIND_W-1:0] v);
      return v & (~v + KIND_W'(1));
   endfunction
endpackage

// File: rtl/cplerr_fifo.sv
module cplerr_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [AW:0]      fill;

   assign full  = (fill == (AW+1)'(DEPTH));
   assign empty = (fill == '0);
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
         if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
         case ({push, pop})
            2'b10:   fill <= fill + (AW+1)'(1);
            2'b01:   fill <= fill - (AW+1)'(1);
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/cplerr_to_mon.sv
module cplerr_to_mon #(
   parameter int NTAG   = 8,
   parameter int TAG_W  = 3,
   parameter int PF_W   = 2,
   parameter int VF_W   = 11,
   parameter int TO_CYC = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [TAG_W-1:0] issue_tag,
   input  logic [PF_W-1:0]  issue_pf,
   input  logic             issue_vfa,
   input  logic [VF_W-1:0]  issue_vf,
   input  logic             done,
   input  logic [TAG_W-1:0] done_tag,
   input  logic             take,
   output logic             pend,
   output logic [PF_W-1:0]  pend_pf,
   output logic             pend_vfa,
   output logic [VF_W-1:0]  pend_vf
);
   localparam int CNT_W = $clog2(TO_CYC + 1);

   logic [NTAG-1:0]            expired;
   logic [NTAG-1:0]            take_oh;
   logic [NTAG-1:0][PF_W-1:0]  slot_pf;
   logic [NTAG-1:0]            slot_vfa;
   logic [NTAG-1:0][VF_W-1:0]  slot_vf;
   logic [TAG_W-1:0]           sel;

   for (genvar g = 0; g < NTAG; g++) begin : g_slot
      logic             act_q, exp_q, vfa_q;
      logic [CNT_W-1:0] cnt_q;
      logic [PF_W-1:0]  pf_q;
      logic [VF_W-1:0]  vf_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q <= 1'b0;
            exp_q <= 1'b0;
            cnt_q <= '0;
            pf_q  <= '0;
            vfa_q <= 1'b0;
            vf_q  <= '0;
         end else begin
            if (issue && issue_tag == TAG_W'(g)) begin
               act_q <= 1'b1;
               cnt_q <= '0;
               pf_q  <= issue_pf;
               vfa_q <= issue_vfa;
               vf_q  <= issue_vfa ? issue_vf : '0;
            end else if (done && done_tag == TAG_W'(g)) begin
               act_q <= 1'b0;
            end else if (act_q) begin
               if (cnt_q == CNT_W'(TO_CYC - 1)) begin
                  act_q <= 1'b0;
                  exp_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            if (take_oh[g]) exp_q <= 1'b0;
         end
      end

      assign expired[g]  = exp_q;
      assign slot_pf[g]  = pf_q;
      assign slot_vfa[g] = vfa_q;
      assign slot_vf[g]  = vf_q;
   end

   // lowest expired tag wins
   always_comb begin
      sel = '0;
      for (int i = NTAG - 1; i >= 0; i--) begin
         if (expired[i]) sel = TAG_W'(i);
      end
   end

   assign pend     = |expired;
   assign take_oh  = (take && pend) ? (NTAG'(1) << sel) : '0;
   assign pend_pf  = slot_pf[sel];
   assign pend_vfa = slot_vfa[sel];
   assign pend_vf  = slot_vf[sel];
endmodule

// File: rtl/cplerr_reporter.sv
module cplerr_reporter #(
   parameter int PF_W       = 2,
   parameter int VF_W       = 11,
   parameter int HDR_W      = 128,
   parameter int FIFO_DEPTH = 4,
   parameter int NUM_TAGS   = 8,
   parameter int CLK_HZ     = 250_000_000,
   parameter int TO_MS      = 50,
   parameter int SIM_TO_CYC = 0,
   localparam int TAG_W     = $clog2(NUM_TAGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_to_uncorr,
   input  logic [3:0]       ev_kind,
   input  logic             ev_log,
   input  logic [HDR_W-1:0] ev_hdr,
   input  logic [PF_W-1:0]  ev_pf,
   input  logic             ev_vf_act,
   input  logic [VF_W-1:0]  ev_vf,
   output logic             ev_ready,
   input  logic             rq_issue,
   input  logic [TAG_W-1:0] rq_tag,
   input  logic [PF_W-1:0]  rq_pf,
   input  logic             rq_vf_act,
   input  logic [VF_W-1:0]  rq_vf,
   input  logic             rq_done,
   input  logic [TAG_W-1:0] rq_done_tag,
   output logic [6:0]       err_strb,
   output logic [PF_W-1:0]  err_pf,
   output logic             err_vf_act,
   output logic [VF_W-1:0]  err_vf,
   output logic [HDR_W-1:0] err_hdr
);
   import cplerr_pkg::*;

   localparam int TO_REAL = (CLK_HZ / 1000) * TO_MS;
   localparam int TO_CYC  = (SIM_TO_CYC > 0) ? SIM_TO_CYC : TO_REAL;
   localparam int ENT_W   = KIND_W + 1 + PF_W + 1 + VF_W + HDR_W;

   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 2");
   end
   if (NUM_TAGS < 2) begin : g_bad_tags
      $error("NUM_TAGS must be at least 2");
   end
   if (TO_CYC < 2) begin : g_bad_to
      $error("timeout window must be at least 2 cycles");
   end
   if (VF_W > 11 || PF_W < 1) begin : g_bad_id
      $error("identity widths out of range");
   end

   // event queue
   logic             push, pop, q_full, q_empty;
   logic [ENT_W-1:0] q_din, q_head;
   logic [KIND_W-1:0] h_kind;
   logic              h_log, h_vfa;
   logic [PF_W-1:0]   h_pf;
   logic [VF_W-1:0]   h_vf;
   logic [HDR_W-1:0]  h_hdr;

   assign ev_ready = !q_full;
   assign push     = (ev_kind != '0) && !q_full;
   assign q_din    = {ev_kind, ev_log, ev_pf, ev_vf_act,
                      (ev_vf_act ? ev_vf : VF_W'(0)), ev_hdr};
   assign {h_kind, h_log, h_pf, h_vfa, h_vf, h_hdr} = q_head;

   cplerr_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .din(q_din), .pop(pop),
      .dout(q_head), .full(q_full), .empty(q_empty)
   );

   // timeout monitor
   logic             to_pend, to_take, to_vfa;
   logic [PF_W-1:0]  to_pf;
   logic [VF_W-1:0]  to_vf;

   cplerr_to_mon #(
      .NTAG(NUM_TAGS), .TAG_W(TAG_W), .PF_W(PF_W), .VF_W(VF_W), .TO_CYC(TO_CYC)
   ) u_to (
      .clk(clk), .rst_n(rst_n),
      .issue(rq_issue), .issue_tag(rq_tag), .issue_pf(rq_pf),
      .issue_vfa(rq_vf_act), .issue_vf(rq_vf),
      .done(rq_done), .done_tag(rq_done_tag),
      .take(to_take), .pend(to_pend),
      .pend_pf(to_pf), .pend_vfa(to_vfa), .pend_vf(to_vf)
   );

   // arbitration: timeouts (bits 0/1) before application kinds (bits 2..5)
   logic [KIND_W-1:0] drained_q, remain, pick;
   logic              use_to, use_app, last;

   assign remain  = h_kind & ~drained_q;
   assign pick    = lowest_kind(remain);
   assign last    = (remain & ~pick) == '0;
   assign use_to  = to_pend;
   assign use_app = !to_pend && !q_empty;
   assign pop     = use_app && last;
   assign to_take = use_to;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drained_q <= '0;
      end else if (use_app) begin
         drained_q <= last ? '0 : (drained_q | pick);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_strb   <= '0;
         err_pf     <= '0;
         err_vf_act <= 1'b0;
         err_vf     <= '0;
         err_hdr    <= '0;
      end else if (use_to) begin
         err_strb   <= cfg_to_uncorr ? ERR_W'(1 << B_TO_UNC) : ERR_W'(1 << B_TO_COR);
         err_pf     <= to_pf;
         err_vf_act <= to_vfa;
         err_vf     <= to_vf;
         err_hdr    <= '0;
      end else if (use_app) begin
         err_strb   <= {h_log, pick, 2'b00};
         err_pf     <= h_pf;
         err_vf_act <= h_vfa;
         err_vf     <= h_vf;
         err_hdr    <= h_log ? h_hdr : '0;
      end else begin
         err_strb   <= '0;
         err_pf     <= '0;
         err_vf_act <= 1'b0;
         err_vf     <= '0;
         err_hdr    <= '0;
      end
   end
endmodule

// File: rtl/cplerr_reporter_chk.sv
module cplerr_reporter_chk #(
   parameter int VF_W  = 11,
   parameter int HDR_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_to_uncorr,
   input logic [6:0]       err_strb,
   input logic             err_vf_act,
   input logic [VF_W-1:0]  err_vf,
   input logic [HDR_W-1:0] err_hdr
);
   // R2: one error kind per cycle
   p_one_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(err_strb[5:0]) <= 1);

   // R4: log bit only rides on an application error
   p_log_with_app_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_strb[6] |-> (err_strb[5:2] != '0));

   // R4: header quiet without log bit
   p_hdr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !err_strb[6] |-> (err_hdr == '0));

   // R5: VF offset zero for a PF reporter
   p_vf_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !err_vf_act |-> (err_vf == '0));

   // R11: timeouts never log a header
   p_to_nolog_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strb[1:0] != '0) |-> !err_strb[6]);

   // R9: timeout bit follows the configuration at emission
   p_cor_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_strb[0] |-> !$past(cfg_to_uncorr));
   p_unc_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_strb[1] |-> $past(cfg_to_uncorr));
endmodule

bind cplerr_reporter cplerr_reporter_chk #(.VF_W(VF_W), .HDR_W(HDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_to_uncorr(cfg_to_uncorr),
   .err_strb(err_strb), .err_vf_act(err_vf_act), .err_vf(err_vf), .err_hdr(err_hdr)
);

// File: tb/cplerr_reporter_bench.sv
module cplerr_reporter_bench;
   localparam int TO = 20;
   localparam int DEPTH = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         cfg_to_uncorr;
   logic [3:0]   ev_kind;
   logic         ev_log;
   logic [127:0] ev_hdr;
   logic [1:0]   ev_pf;
   logic         ev_vf_act;
   logic [10:0]  ev_vf;
   logic         ev_ready;
   logic         rq_issue;
   logic [2:0]   rq_tag;
   logic [1:0]   rq_pf;
   logic         rq_vf_act;
   logic [10:0]  rq_vf;
   logic         rq_done;
   logic [2:0]   rq_done_tag;
   logic [6:0]   err_strb;
   logic [1:0]   err_pf;
   logic         err_vf_act;
   logic [10:0]  err_vf;
   logic [127:0] err_hdr;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cplerr_reporter #(.FIFO_DEPTH(DEPTH), .NUM_TAGS(8), .SIM_TO_CYC(TO)) u_cplerr_reporter (
      .clk(clk), .rst_n(rst_n), .cfg_to_uncorr(cfg_to_uncorr),
      .ev_kind(ev_kind), .ev_log(ev_log), .ev_hdr(ev_hdr), .ev_pf(ev_pf),
      .ev_vf_act(ev_vf_act), .ev_vf(ev_vf), .ev_ready(ev_ready),
      .rq_issue(rq_issue), .rq_tag(rq_tag), .rq_pf(rq_pf), .rq_vf_act(rq_vf_act),
      .rq_vf(rq_vf), .rq_done(rq_done), .rq_done_tag(rq_done_tag),
      .err_strb(err_strb), .err_pf(err_pf), .err_vf_act(err_vf_act),
      .err_vf(err_vf), .err_hdr(err_hdr)
   );

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic idle_inputs();
      ev_kind = '0; ev_log = 0; ev_hdr = '0; ev_pf = '0; ev_vf_act = 0; ev_vf = '0;
      rq_issue = 0; rq_tag = '0; rq_pf = '0; rq_vf_act = 0; rq_vf = '0;
      rq_done = 0; rq_done_tag = '0;
   endtask

   // present an event for one cycle; returns one negedge later
   task automatic send_ev(input logic [3:0] k, input logic lg, input logic [1:0] pf,
                          input logic vfa, input logic [10:0] vf, input logic [127:0] hdr);
      ev_kind = k; ev_log = lg; ev_pf = pf; ev_vf_act = vfa; ev_vf = vf; ev_hdr = hdr;
      @(negedge clk);
      ev_kind = '0; ev_log = 0; ev_hdr = '0;
   endtask

   task automatic issue_req(input logic [2:0] tag, input logic [1:0] pf,
                            input logic vfa, input logic [10:0] vf);
      rq_issue = 1; rq_tag = tag; rq_pf = pf; rq_vf_act = vfa; rq_vf = vf;
      @(negedge clk);
      rq_issue = 0;
   endtask

   task automatic t_reset();
      chk("R1 strobe", 128'(err_strb), 0);
      chk("R1 identity", 128'({err_pf, err_vf_act, err_vf}), 0);
      chk("R1 header", err_hdr, 0);
      chk("R1 ready", 128'(ev_ready), 1);
   endtask

   task automatic t_single();
      for (int j = 0; j < 4; j++) begin
         logic [127:0] hdr = {4{32'hC0DE_0000 | 32'(j)}};
         logic lg = j[0];
         send_ev(4'(1 << j), lg, 2'(j), 1'b1, 11'(100 + j), hdr);
         tick(1);
         chk("R2 R4 strobe bit", 128'(err_strb), 128'((1 << (j + 2)) | (int'(lg) << 6)));
         chk("R5 vf identity", 128'({err_pf, err_vf_act, err_vf}), 128'({2'(j), 1'b1, 11'(100 + j)}));
         chk("R4 header", err_hdr, lg ? hdr : 128'd0);
         tick(1);
         chk("R2 one cycle", 128'(err_strb), 0);
      end
   endtask

   task automatic t_pf_id();
      send_ev(4'b0100, 1'b0, 2'd3, 1'b0, 11'h3FF, 128'hDEAD);
      tick(1);
      chk("R5 pf strobe", 128'(err_strb), 128'h10);
      chk("R5 pf identity", 128'({err_pf, err_vf_act, err_vf}), 128'({2'd3, 1'b0, 11'd0}));
      chk("R4 no log header", err_hdr, 0);
      tick(1);
   endtask

   task automatic t_multi();
      send_ev(4'b1011, 1'b1, 2'd1, 1'b1, 11'd5, 128'h1234_5678);
      tick(1); chk("R3 first lowest", 128'(err_strb), 128'h44);
      tick(1); chk("R3 second", 128'(err_strb), 128'h48);
      tick(1); chk("R3 third", 128'(err_strb), 128'h60);
      chk("R4 header kept", err_hdr, 128'h1234_5678);
      tick(1); chk("R3 done", 128'(err_strb), 0);
   endtask

   task automatic t_fifo();
      bit saw_full = 0;
      fork
         begin
            for (int e = 0; e < 5; e++) begin
               while (!ev_ready) begin
                  saw_full = 1;
                  @(negedge clk);
               end
               send_ev(4'b1111, 1'b0, 2'(e % 4), 1'b1, 11'(e + 1), '0);
            end
         end
         begin
            int got = 0;
            for (int c = 0; c < 80 && got < 20; c++) begin
               @(negedge clk);
               if (err_strb != '0) begin
                  chk("R6 order kind", 128'(err_strb), 128'(1 << (2 + got % 4)));
                  chk("R6 order id", 128'({err_pf, err_vf}),
                      128'({2'((got / 4) % 4), 11'(got / 4 + 1)}));
                  got++;
               end
            end
            chk("R6 none dropped", 128'(got), 20);
         end
      join
      chk("R6 ready low when full", 128'(saw_full), 1);
      tick(2);
   endtask

   task automatic t_timeout(input logic cfg, input logic [2:0] tag);
      cfg_to_uncorr = cfg;
      issue_req(tag, 2'd2, 1'b1, 11'd33);
      tick(TO);
      chk("R7 not early", 128'(err_strb), 0);
      tick(1);
      chk("R7 R9 R11 timeout strobe", 128'(err_strb), cfg ? 128'h02 : 128'h01);
      chk("R7 timeout identity", 128'({err_pf, err_vf_act, err_vf}), 128'({2'd2, 1'b1, 11'd33}));
      tick(1);
      chk("R7 reported once", 128'(err_strb), 0);
      cfg_to_uncorr = 0;
   endtask

   task automatic t_cancel();
      int seen = 0;
      issue_req(3'd6, 2'd1, 1'b0, 11'd0);
      tick(TO - 1);
      rq_done = 1; rq_done_tag = 3'd6;
      @(negedge clk);
      rq_done = 0;
      for (int c = 0; c < 8; c++) begin
         if (err_strb != '0) seen++;
         @(negedge clk);
      end
      chk("R8 late completion cancels", 128'(seen), 0);
   endtask

   task automatic t_prio();
      cfg_to_uncorr = 0;
      issue_req(3'd4, 2'd0, 1'b0, 11'd0);
      tick(TO - 2);
      send_ev(4'b1111, 1'b0, 2'd3, 1'b0, 11'd0, '0);
      tick(1); chk("R10 app before expiry", 128'(err_strb), 128'h04);
      tick(1); chk("R10 timeout first", 128'(err_strb), 128'h01);
      tick(1); chk("R10 resume bit3", 128'(err_strb), 128'h08);
      tick(1); chk("R10 resume bit4", 128'(err_strb), 128'h10);
      tick(1); chk("R10 resume bit5", 128'(err_strb), 128'h20);
      tick(1); chk("R10 done", 128'(err_strb), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0;
      cfg_to_uncorr = 0;
      idle_inputs();
      tick(3);
      rst_n = 1;
      tick(1);
      t_reset();
      t_single();
      t_pf_id();
      t_multi();
      t_fifo();
      t_timeout(1'b0, 3'd3);
      t_timeout(1'b1, 3'd0);
      t_cancel();
      t_prio();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule